// File: doc/BRIEF.md
# Serial Receive Status Flag Controller

This block sits beside a serial receiver's shift register and owns the two status flags that software and a DMA engine use to collect received bytes. These are a "byte ready" flag and an "overrun" flag. When the receiver reports a finished character, the block either moves the byte into the holding data register and raises the ready flag, or records an overrun when the previous byte has not been collected yet. An overrun keeps the earlier byte and drops the new one.

Software clears a flag by writing 0 to it. That write only takes effect if the flag was read as 1 beforehand. A DMA acknowledge also clears the ready flag. Writes can never set a flag. While an overrun is pending, the block tells the receiver to stop accepting characters. In clocked synchronous mode it also tells the transmitter to stop. It raises interrupt requests from the flags when the matching enables are set.

Top module: `rx_status_flags`

## Requirements
- R1: When `rxDone` is high, `rxEnable` is high and both flags are 0, `rdData` takes `rxByte` and `fullFlag` becomes 1 on the next clock.
- R2: A `stsWr` with `wrFull`=0 clears `fullFlag` only when a `stsRd` returned `fullFlag`=1 after the flag last became 1 and before this write. Without such a read, the write leaves the flag unchanged. A qualifying read is used up by any write of 0 to that flag, and it is lost whenever the flag drops to 0.
- R3: `dmaAck` clears `fullFlag` on the next clock, with no prior read needed.
- R4: A completed reception while `fullFlag` is 1 sets `ovrFlag` and leaves `rdData` unchanged, so the new byte is lost. This holds even when `fullFlag` is cleared in that same cycle.
- R5: While `ovrFlag` is 1, `rxInhibit` is 1 and `rxDone` has no effect. While `rxEnable` is 0, `rxInhibit` is 1 and `rxDone` has no effect. `txInhibit` is 1 exactly when `ovrFlag` is 1 and `syncMode` is 1.
- R6: `ovrFlag` clears only through a `stsWr` with `wrOvr`=0 that follows a `stsRd` which returned `ovrFlag`=1. `dmaAck` has no effect on it.
- R7: Driving `rxEnable` to 0 leaves both `fullFlag` and `ovrFlag` at their current values.
- R8: A `stsWr` with a bit at 1 never sets the matching flag and leaves it unchanged.
- R9: When a reception is accepted with `fullFlag`=0 and `dmaAck` is high in the same cycle, the set wins and `fullFlag` ends at 1.
- R10: `rxIrq` equals `fullFlag` AND `rxIntEn`. `errIrq` equals `ovrFlag` AND `errIntEn`.
- R11: While `rstN` is low, both flags, their read qualifications and `rdData` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxDone | input | 1 | One-cycle pulse: the shifter finished a character |
| rxByte | input | DATA_W | Byte assembled by the shifter |
| rxEnable | input | 1 | Receive enable |
| syncMode | input | 1 | 1 selects clocked synchronous mode |
| stsRd | input | 1 | CPU reads the status register this cycle |
| stsWr | input | 1 | CPU writes the status register this cycle |
| wrFull | input | 1 | Write data bit for the ready flag |
| wrOvr | input | 1 | Write data bit for the overrun flag |
| dmaAck | input | 1 | DMA read of the data register completed |
| rxIntEn | input | 1 | Receive interrupt enable |
| errIntEn | input | 1 | Error interrupt enable |
| rdData | output | DATA_W | Receive data register contents |
| fullFlag | output | 1 | Byte-ready flag |
| ovrFlag | output | 1 | Overrun flag |
| rxIrq | output | 1 | Receive interrupt request |
| errIrq | output | 1 | Error interrupt request |
| rxInhibit | output | 1 | Tells the receiver to accept no character |
| txInhibit | output | 1 | Tells the transmitter to hold |

## Verification
The embedded properties watch, on every clock, these cycle-local rules:
- the load-and-set on an accepted byte;
- the data hold and overrun set on a byte arriving while the ready flag is up;
- the rule that a flag rising needs a hardware event;
- the rule that a flag falling needs a write of 0 or a DMA acknowledge;
- the inhibit outputs.

The read-then-write qualification spans an arbitrary number of cycles and is lost when the flag drops, so only the bench scenarios can show it: the ignored bare write, the qualification lost after a DMA clear, the set-versus-clear collision, and the overrun that coincides with a DMA clear. Those scenarios run against a behavioural model that is compared on every clock.

// File: rtl/rx_status_pkg.sv
package rx_status_pkg;
  localparam int FLAG_FULL = 0;
  localparam int FLAG_OVR  = 1;
  localparam int NUM_FLAGS = 2;

  typedef struct packed {
    logic loadData;
  } dpStrobe_t;
endpackage

// File: rtl/rx_status_dp.sv
module rx_status_dp
  import rx_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] rxByte,
  output logic [DATA_W-1:0] dataQ
);
  always_ff @(posedge clk) begin
    if (!rstN)              dataQ <= '0;
    else if (strb.loadData) dataQ <= rxByte;
  end
endmodule

// File: rtl/rx_status_ctl.sv
module rx_status_ctl
  import rx_status_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxDone,
  input  logic                 rxEnable,
  input  logic                 syncMode,
  input  logic                 stsRd,
  input  logic                 stsWr,
  input  logic [NUM_FLAGS-1:0] wrBits,
  input  logic                 dmaAck,
  output logic [NUM_FLAGS-1:0] flagQ,
  output dpStrobe_t            strb,
  output logic                 rxInhibit,
  output logic                 txInhibit
);
  logic [NUM_FLAGS-1:0] armQ;
  logic [NUM_FLAGS-1:0] setEv;
  logic [NUM_FLAGS-1:0] hwClr;
  logic                 accept;

  // a character only counts when enabled and no overrun is pending
  assign accept = rxDone & rxEnable & ~flagQ[FLAG_OVR];

  always_comb begin
    setEv[FLAG_FULL] = accept & ~flagQ[FLAG_FULL];
    setEv[FLAG_OVR]  = accept &  flagQ[FLAG_FULL];
    hwClr[FLAG_FULL] = dmaAck;
    hwClr[FLAG_OVR]  = 1'b0;
  end

  assign strb.loadData = setEv[FLAG_FULL];
  assign rxInhibit     = flagQ[FLAG_OVR] | ~rxEnable;
  assign txInhibit     = flagQ[FLAG_OVR] & syncMode;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    logic wrZero, swClr, flagNext, armNext;
    assign wrZero   = stsWr & ~wrBits[i];
    assign swClr    = wrZero & armQ[i];
    // hardware set outranks any clear in the same cycle
    assign flagNext = setEv[i] | (flagQ[i] & ~swClr & ~hwClr[i]);
    // qualification: earned by reading a 1, spent by a write of 0, lost when the flag drops
    assign armNext  = flagNext & ~wrZero & (armQ[i] | (stsRd & flagQ[i]));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        flagQ[i] <= 1'b0;
        armQ[i]  <= 1'b0;
      end else begin
        flagQ[i] <= flagNext;
        armQ[i]  <= armNext;
      end
    end
  end

  // R2 R3: the ready flag only falls after a write of 0 or a DMA acknowledge
  p_full_fall_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagQ[FLAG_FULL]) |-> $past(dmaAck || (stsWr && !wrBits[FLAG_FULL])));

  // R6: the overrun flag only falls after a write of 0 to it
  p_ovr_fall_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagQ[FLAG_OVR]) |-> $past(stsWr && !wrBits[FLAG_OVR]));

  // R8: no flag rises without a received character
  p_no_sw_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ[FLAG_FULL]) || $rose(flagQ[FLAG_OVR]) |-> $past(rxDone && rxEnable));

  // R5: a pending overrun always inhibits reception
  p_ovr_inhibit_r5: assert property (@(posedge clk) disable iff (!rstN)
    flagQ[FLAG_OVR] |-> rxInhibit);
endmodule

// File: rtl/rx_status_flags.sv
module rx_status_flags
  import rx_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxDone,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              rxEnable,
  input  logic              syncMode,
  input  logic              stsRd,
  input  logic              stsWr,
  input  logic              wrFull,
  input  logic              wrOvr,
  input  logic              dmaAck,
  input  logic              rxIntEn,
  input  logic              errIntEn,
  output logic [DATA_W-1:0] rdData,
  output logic              fullFlag,
  output logic              ovrFlag,
  output logic              rxIrq,
  output logic              errIrq,
  output logic              rxInhibit,
  output logic              txInhibit
);
  dpStrobe_t            strb;
  logic [NUM_FLAGS-1:0] flagQ;
  logic [NUM_FLAGS-1:0] wrBits;

  always_comb begin
    wrBits[FLAG_FULL] = wrFull;
    wrBits[FLAG_OVR]  = wrOvr;
  end

  rx_status_ctl ctl_i (
    .clk(clk), .rstN(rstN), .rxDone(rxDone), .rxEnable(rxEnable),
    .syncMode(syncMode), .stsRd(stsRd), .stsWr(stsWr), .wrBits(wrBits),
    .dmaAck(dmaAck), .flagQ(flagQ), .strb(strb),
    .rxInhibit(rxInhibit), .txInhibit(txInhibit)
  );

  rx_status_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rxByte(rxByte), .dataQ(rdData)
  );

  assign fullFlag = flagQ[FLAG_FULL];
  assign ovrFlag  = flagQ[FLAG_OVR];
  assign rxIrq    = fullFlag & rxIntEn;
  assign errIrq   = ovrFlag & errIntEn;

  // R1: accepted byte lands in the data register with the ready flag up
  p_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    rxDone && rxEnable && !ovrFlag && !fullFlag |=> fullFlag && rdData == $past(rxByte));

  // R4: a byte arriving on a full register raises overrun and keeps old data
  p_overrun_keep_r4: assert property (@(posedge clk) disable iff (!rstN)
    rxDone && rxEnable && !ovrFlag && fullFlag |=> ovrFlag && $stable(rdData));

  // R5: data register frozen while an overrun is pending
  p_ovr_freeze_r5: assert property (@(posedge clk) disable iff (!rstN)
    ovrFlag |=> $stable(rdData));

  // R7: without a write, the overrun flag holds whatever rxEnable does
  p_ovr_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    ovrFlag && !stsWr |=> ovrFlag);
endmodule

// File: tb/rx_status_flags_tb_top.sv
`timescale 1ns/1ps
module rx_status_flags_tb_top;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxDone = 0, rxEnable = 1, syncMode = 0, stsRd = 0, stsWr = 0;
  logic wrFull = 1, wrOvr = 1, dmaAck = 0, rxIntEn = 0, errIntEn = 0;
  logic [DW-1:0] rxByte = '0;
  logic [DW-1:0] rdData;
  logic fullFlag, ovrFlag, rxIrq, errIrq, rxInhibit, txInhibit;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rx_status_flags #(.DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .rxDone(rxDone), .rxByte(rxByte),
    .rxEnable(rxEnable), .syncMode(syncMode), .stsRd(stsRd), .stsWr(stsWr),
    .wrFull(wrFull), .wrOvr(wrOvr), .dmaAck(dmaAck), .rxIntEn(rxIntEn),
    .errIntEn(errIntEn), .rdData(rdData), .fullFlag(fullFlag),
    .ovrFlag(ovrFlag), .rxIrq(rxIrq), .errIrq(errIrq),
    .rxInhibit(rxInhibit), .txInhibit(txInhibit)
  );

  // behavioural reference
  bit mFull, mOvr, mArmF, mArmO;
  bit [DW-1:0] mData;

  always @(posedge clk) begin
    bit take, nFull, nOvr;
    if (!rstN) begin
      mFull = 0; mOvr = 0; mArmF = 0; mArmO = 0; mData = '0;
    end else begin
      take  = rxDone && rxEnable && !mOvr;
      nFull = mFull;
      nOvr  = mOvr;
      if (dmaAck || (stsWr && !wrFull && mArmF)) nFull = 0;
      if (stsWr && !wrOvr && mArmO) nOvr = 0;
      if (take && !mFull) begin nFull = 1; mData = rxByte; end
      if (take && mFull) nOvr = 1;
      if (!nFull || (stsWr && !wrFull)) mArmF = 0;
      else if (stsRd && mFull) mArmF = 1;
      if (!nOvr || (stsWr && !wrOvr)) mArmO = 0;
      else if (stsRd && mOvr) mArmO = 1;
      mFull = nFull;
      mOvr  = nOvr;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison, sampled mid-cycle
  always @(posedge clk) begin
    #5;
    if (rstN && !finished) begin
      chk(rdData == mData, "R1 model rdData", rdData, mData);
      chk(fullFlag == mFull, "R2 model fullFlag", fullFlag, mFull);
      chk(ovrFlag == mOvr, "R4 model ovrFlag", ovrFlag, mOvr);
      chk(rxIrq == (mFull && rxIntEn), "R10 model rxIrq", rxIrq, mFull && rxIntEn);
      chk(errIrq == (mOvr && errIntEn), "R10 model errIrq", errIrq, mOvr && errIntEn);
      chk(rxInhibit == (mOvr || !rxEnable), "R5 model rxInhibit", rxInhibit, mOvr || !rxEnable);
      chk(txInhibit == (mOvr && syncMode), "R5 model txInhibit", txInhibit, mOvr && syncMode);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    rxDone = 0; stsRd = 0; stsWr = 0; dmaAck = 0; wrFull = 1; wrOvr = 1;
  endtask

  task automatic recv(input logic [DW-1:0] b);
    rxDone = 1; rxByte = b; tick(); idle();
  endtask

  task automatic rdSts();
    stsRd = 1; tick(); idle();
  endtask

  task automatic wrSts(input logic f, input logic o);
    stsWr = 1; wrFull = f; wrOvr = o; tick(); idle();
  endtask

  task automatic dma();
    dmaAck = 1; tick(); idle();
  endtask

  initial begin
    repeat (3) tick();
    chk(fullFlag == 0, "R11 reset fullFlag", fullFlag, 0);
    chk(ovrFlag == 0, "R11 reset ovrFlag", ovrFlag, 0);
    chk(rdData == 0, "R11 reset rdData", rdData, 0);
    rstN = 1;
    tick();

    rxIntEn = 1; errIntEn = 1;
    recv(8'hA5);
    chk(fullFlag == 1, "R1 full set", fullFlag, 1);
    chk(rdData == 8'hA5, "R1 data loaded", rdData, 8'hA5);
    chk(rxIrq == 1, "R10 rxIrq", rxIrq, 1);

    wrSts(0, 1);
    chk(fullFlag == 1, "R2 bare write0 ignored", fullFlag, 1);
    rdSts(); tick(); wrSts(0, 1);
    chk(fullFlag == 0, "R2 read then write0 clears", fullFlag, 0);

    recv(8'h3C);
    wrSts(1, 1);
    chk(fullFlag == 1, "R8 write1 keeps full", fullFlag, 1);
    chk(ovrFlag == 0, "R8 write1 never sets ovr", ovrFlag, 0);
    dma();
    chk(fullFlag == 0, "R3 dma clears full", fullFlag, 0);

    recv(8'h11); recv(8'h22);
    chk(ovrFlag == 1, "R4 overrun set", ovrFlag, 1);
    chk(rdData == 8'h11, "R4 old data kept", rdData, 8'h11);
    chk(errIrq == 1, "R10 errIrq", errIrq, 1);
    chk(rxInhibit == 1, "R5 rx inhibited", rxInhibit, 1);
    chk(txInhibit == 0, "R5 async tx free", txInhibit, 0);
    syncMode = 1; #1;
    chk(txInhibit == 1, "R5 sync tx inhibited", txInhibit, 1);
    syncMode = 0;
    dma();
    chk(ovrFlag == 1, "R6 dma leaves ovr", ovrFlag, 1);
    recv(8'h33);
    chk(fullFlag == 0, "R5 rx ignored during ovr", fullFlag, 0);
    chk(rdData == 8'h11, "R5 data untouched during ovr", rdData, 8'h11);

    rxEnable = 0; tick(); tick();
    chk(ovrFlag == 1, "R7 ovr kept on disable", ovrFlag, 1);
    rxEnable = 1;
    wrSts(1, 0);
    chk(ovrFlag == 1, "R6 bare write0 ignored", ovrFlag, 1);
    rdSts(); wrSts(1, 0);
    chk(ovrFlag == 0, "R6 read then write0 clears", ovrFlag, 0);

    rxEnable = 0; recv(8'h44);
    chk(fullFlag == 0, "R5 rx ignored when disabled", fullFlag, 0);
    rxEnable = 1; recv(8'h55);
    rxEnable = 0; tick(); tick();
    chk(fullFlag == 1, "R7 full kept on disable", fullFlag, 1);
    rxEnable = 1;

    rxDone = 1; rxByte = 8'h99; dmaAck = 1; tick(); idle();
    chk(ovrFlag == 1, "R4 overrun with same-cycle dma", ovrFlag, 1);
    chk(fullFlag == 0, "R4 dma still clears full", fullFlag, 0);
    chk(rdData == 8'h55, "R4 data kept on collision", rdData, 8'h55);
    rdSts(); wrSts(1, 0);

    rxDone = 1; rxByte = 8'h66; dmaAck = 1; tick(); idle();
    chk(fullFlag == 1, "R9 set beats dma clear", fullFlag, 1);
    chk(rdData == 8'h66, "R9 data loaded", rdData, 8'h66);

    rdSts(); dma(); recv(8'h77);
    wrSts(0, 1);
    chk(fullFlag == 1, "R2 qualification lost after dma", fullFlag, 1);
    rxIntEn = 0; #1;
    chk(rxIrq == 0, "R10 rxIrq masked", rxIrq, 0);

    tick(); tick();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule